// File: doc/BRIEF.md
# Half-Duplex Turnaround Timing Controller

This block sets the transmit timing of a single-wire, half-duplex, UART-style debug link. When the link leaves receive mode for transmit mode, it holds back the first outgoing byte for a programmable guard time, counted in bit periods. Inside a multi-byte read burst it can add a fixed gap of two idle characters in front of each byte after the first.

A response watchdog raises a time-out when the internal access layer is too slow to deliver a response. Two further control bits do the following. One tells the receiver to ignore parity. The other holds back response-signature bytes, which are skipped instead of sent.

The serializer sits outside the block. It presents each byte with `byte_ready`, starts sending on `tx_start`, and reports the end of the byte with `byte_done`.

Top module: `turnaround_timer`

## Requirements
- R1: After reset, `tx_start`, `sig_skip`, `tmo_flag` and `par_ignore` are all 0, and every control input reads as 0 (guard code 0, all options off).
- R2: For a guard code g from 0 to 6, after `rx_mode` goes from 1 to 0, `tx_start` is not raised until exactly 128 >> g rising edges of `bit_tick` have been counted, with a byte ready the whole time.
- R3: Guard code 7 adds no guard. With `byte_ready` high, `tx_start` rises in the first cycle after the edge at which `rx_mode` is seen low.
- R4: `tx_start` is a one-cycle pulse. It is raised only while the delay has run out and `byte_ready` is high, and never while `rx_mode` is 1.
- R5: With `cfg_gap_en` = 1 and `burst` = 1, each byte after `byte_done` waits exactly 24 bit ticks before `tx_start`. This is two idle characters of 12 bit periods each.
- R6: The first byte after a receive-to-transmit switch always uses the guard time, never the inter-byte gap.
- R7: With `cfg_gap_en` = 0 or `burst` = 0, the next byte after `byte_done` starts with no added delay.
- R8: With `cfg_tmo_off` = 0, `tmo_flag` rises after TMO_CYCLES consecutive clock edges with `resp_wait` = 1 and `resp_ready` = 0. A `resp_ready` pulse restarts the count. Lowering `resp_wait` clears the flag.
- R9: With `cfg_tmo_off` = 1, `tmo_flag` never rises. Clearing the bit again starts a fresh count of TMO_CYCLES.
- R10: Raising `rx_mode` or a time-out cancels any pending delay and returns the controller to idle. No `tx_start` is issued until the next 1-to-0 change of `rx_mode`, and that change starts a full guard time.
- R11: `par_ignore` is 1 exactly when `cfg_par_off` = 1 and `rx_mode` = 1.
- R12: With `cfg_sig_off` = 1, a ready byte flagged by `byte_is_sig` gets no `tx_start`. `sig_skip` is raised instead. With `cfg_sig_off` = 0, the same byte starts normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gap_en | input | 1 | Enable the two-character inter-byte gap |
| cfg_par_off | input | 1 | Ignore received parity |
| cfg_tmo_off | input | 1 | Switch off the response watchdog |
| cfg_sig_off | input | 1 | Suppress response-signature bytes |
| cfg_guard_sel | input | 3 | Guard code: 128 >> code ticks, code 7 means no guard |
| bit_tick | input | 1 | One-cycle strobe per bit period |
| rx_mode | input | 1 | 1 = link receiving, 0 = link transmitting |
| burst | input | 1 | A multi-byte load response is being sent |
| byte_ready | input | 1 | Serializer holds a byte to send |
| byte_is_sig | input | 1 | The ready byte is a response signature |
| byte_done | input | 1 | Serializer finished the current byte |
| resp_wait | input | 1 | A response from the access layer is outstanding |
| resp_ready | input | 1 | Strobe: the response has arrived |
| tx_start | output | 1 | One-cycle pulse: start sending the ready byte |
| sig_skip | output | 1 | Ready signature byte is dropped, not sent |
| tmo_flag | output | 1 | Response time-out |
| par_ignore | output | 1 | Receiver must ignore parity |

## Verification
Every guard code is swept, and the bit ticks counted up to `tx_start` are compared with 128 >> code. Code 7 separates a zero guard from an off-by-one. All four combinations of gap enable and burst are run over a three-byte transfer. This separates the first byte's guard from the inter-byte gap, and a gap from no gap. The watchdog is run straight through, restarted by a `resp_ready` pulse, and held off by its disable bit, which shows whether the count starts from zero. A receive re-entry part way through the guard and a time-out abort both show whether a pending delay is discarded.

// File: rtl/tt_pkg.sv
package tt_pkg;
  typedef enum logic [1:0] {TT_IDLE, TT_WAIT, TT_BUSY} tt_state_e;

  // guard length in bit ticks; code 7 removes the guard
  function automatic int unsigned guard_ticks(input logic [2:0] sel, input int unsigned gmax);
    return (sel == 3'd7) ? 0 : (gmax >> sel);
  endfunction

  function automatic int unsigned gap_ticks(input int unsigned char_bits, input int unsigned chars);
    return char_bits * chars;
  endfunction
endpackage

// File: rtl/tt_tick_delay.sv
module tt_tick_delay #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (clear)               cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (tick && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  p_hold_no_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clear && !load) |=> $stable(cnt));
endmodule

// File: rtl/tt_resp_watchdog.sv
module tt_resp_watchdog #(
  parameter int LIMIT = 65536
) (
  input  logic clk,
  input  logic rst_n,
  input  logic off_i,
  input  logic wait_i,
  input  logic ready_i,
  output logic tmo_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;
  logic          counting;

  assign counting = wait_i && !ready_i && !off_i && !tmo_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      tmo_o <= 1'b0;
    end else begin
      if (!wait_i)                                 tmo_o <= 1'b0;
      else if (counting && cnt == CW'(LIMIT - 1))  tmo_o <= 1'b1;
      cnt <= counting ? cnt + 1'b1 : '0;
    end
  end

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (off_i && !tmo_o) |=> !tmo_o);
  p_flag_needs_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_o) |-> $past(wait_i));
  p_ready_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && !tmo_o) |=> !tmo_o);
endmodule

// File: rtl/turnaround_timer.sv
module turnaround_timer
  import tt_pkg::*;
#(
  parameter int GUARD_MAX  = 128,
  parameter int CHAR_BITS  = 12,
  parameter int GAP_CHARS  = 2,
  parameter int TMO_CYCLES = 65536
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_gap_en,
  input  logic       cfg_par_off,
  input  logic       cfg_tmo_off,
  input  logic       cfg_sig_off,
  input  logic [2:0] cfg_guard_sel,
  input  logic       bit_tick,
  input  logic       rx_mode,
  input  logic       burst,
  input  logic       byte_ready,
  input  logic       byte_is_sig,
  input  logic       byte_done,
  input  logic       resp_wait,
  input  logic       resp_ready,
  output logic       tx_start,
  output logic       sig_skip,
  output logic       tmo_flag,
  output logic       par_ignore
);
  localparam int GAP_LEN = CHAR_BITS * GAP_CHARS;
  localparam int MAX_LEN = (GUARD_MAX > GAP_LEN) ? GUARD_MAX : GAP_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  tt_state_e        state, state_n;
  logic             rx_q, rx_fall, abort;
  logic             dly_load, dly_done, slot_open, sig_drop;
  logic [CNT_W-1:0] dly_val, guard_val, gap_val;

  assign guard_val = CNT_W'(guard_ticks(cfg_guard_sel, GUARD_MAX));
  assign gap_val   = CNT_W'(gap_ticks(CHAR_BITS, GAP_CHARS));
  assign rx_fall   = rx_q && !rx_mode;
  assign abort     = rx_mode || tmo_flag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= TT_IDLE;
      rx_q  <= 1'b1;
    end else begin
      state <= state_n;
      rx_q  <= rx_mode;
    end
  end

  always_comb begin
    state_n  = state;
    dly_load = 1'b0;
    dly_val  = '0;
    if (abort) begin
      state_n = TT_IDLE;
    end else begin
      case (state)
        TT_IDLE: if (rx_fall) begin
          state_n  = TT_WAIT;
          dly_load = 1'b1;
          dly_val  = guard_val;
        end
        TT_WAIT: if (tx_start) state_n = TT_BUSY;
        TT_BUSY: if (byte_done) begin
          state_n  = TT_WAIT;
          dly_load = 1'b1;
          dly_val  = (cfg_gap_en && burst) ? gap_val : '0;
        end
        default: state_n = TT_IDLE;
      endcase
    end
  end

  tt_tick_delay #(.CNT_W(CNT_W)) i_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (abort),
    .load     (dly_load),
    .load_val (dly_val),
    .tick     (bit_tick),
    .done     (dly_done)
  );

  tt_resp_watchdog #(.LIMIT(TMO_CYCLES)) i_wdog (
    .clk     (clk),
    .rst_n   (rst_n),
    .off_i   (cfg_tmo_off),
    .wait_i  (resp_wait),
    .ready_i (resp_ready),
    .tmo_o   (tmo_flag)
  );

  // named internal events
  assign slot_open  = (state == TT_WAIT) && dly_done && byte_ready && !abort;
  assign sig_drop   = byte_is_sig && cfg_sig_off;
  assign tx_start   = slot_open && !sig_drop;
  assign sig_skip   = slot_open && sig_drop;
  assign par_ignore = cfg_par_off && rx_mode;

  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);
  p_quiet_in_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode |-> !tx_start);
  p_tmo_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_flag |=> (state == TT_IDLE));
  p_sig_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_is_sig && cfg_sig_off) |-> !tx_start);
  p_fall_arms_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TT_IDLE && rx_fall && !tmo_flag) |=> (state == TT_WAIT));
endmodule

// File: tb/test_turnaround_timer.sv
module test_turnaround_timer;
  localparam int T = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_gap_en, cfg_par_off, cfg_tmo_off, cfg_sig_off;
  logic [2:0] cfg_guard_sel;
  logic bit_tick, rx_mode, burst, byte_ready, byte_is_sig, byte_done, resp_wait, resp_ready;
  logic tx_start, sig_skip, tmo_flag, par_ignore;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  turnaround_timer #(.TMO_CYCLES(T)) i_turnaround_timer (
    .clk(clk), .rst_n(rst_n), .cfg_gap_en(cfg_gap_en), .cfg_par_off(cfg_par_off),
    .cfg_tmo_off(cfg_tmo_off), .cfg_sig_off(cfg_sig_off), .cfg_guard_sel(cfg_guard_sel),
    .bit_tick(bit_tick), .rx_mode(rx_mode), .burst(burst), .byte_ready(byte_ready),
    .byte_is_sig(byte_is_sig), .byte_done(byte_done), .resp_wait(resp_wait),
    .resp_ready(resp_ready), .tx_start(tx_start), .sig_skip(sig_skip),
    .tmo_flag(tmo_flag), .par_ignore(par_ignore)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // count ticks until tx_start is seen; returns at a negedge with tx_start high
  task automatic measure(output int n);
    n = 0;
    while (!tx_start && n < 300) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      n++;
    end
  endtask

  task automatic tick_n(input int k);
    for (int i = 0; i < k; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  // back to receive, then switch to transmit
  task automatic turnaround();
    rx_mode = 1'b1;
    @(negedge clk);
    rx_mode = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    int n;
    int exp;
    rst_n = 1'b0; cfg_gap_en = 0; cfg_par_off = 0; cfg_tmo_off = 0; cfg_sig_off = 0;
    cfg_guard_sel = 3'd0; bit_tick = 0; rx_mode = 1; burst = 0; byte_ready = 0;
    byte_is_sig = 0; byte_done = 0; resp_wait = 0; resp_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_start", int'(tx_start), 0);
    chk("R1 sig_skip", int'(sig_skip), 0);
    chk("R1 tmo_flag", int'(tmo_flag), 0);
    chk("R1 par_ignore", int'(par_ignore), 0);

    // R2 / R3: full guard sweep
    for (int g = 0; g < 8; g++) begin
      cfg_guard_sel = 3'(g);
      byte_ready = 1'b1;
      rx_mode = 1'b1;
      @(negedge clk);
      chk("R4 no start in rx", int'(tx_start), 0);
      rx_mode = 1'b0;
      @(negedge clk);
      measure(n);
      exp = (g == 7) ? 0 : (128 >> g);
      chk((g == 7) ? "R3 guard off" : "R2 guard ticks", n, exp);
      @(negedge clk);
      chk("R4 single pulse", int'(tx_start), 0);
    end

    // R4: no start without a ready byte
    cfg_guard_sel = 3'd5;
    byte_ready = 1'b0;
    turnaround();
    for (int i = 0; i < 10; i++) begin
      tick_n(1);
      if (tx_start) chk("R4 start without byte", 1, 0);
    end
    chk("R4 start without byte", int'(tx_start), 0);
    byte_ready = 1'b1;
    #1;
    chk("R4 start once ready", int'(tx_start), 1);
    @(negedge clk);

    // R5 / R6 / R7: gap enable x burst over three bytes
    for (int ge = 0; ge < 2; ge++) begin
      for (int bu = 0; bu < 2; bu++) begin
        cfg_guard_sel = 3'd7;
        cfg_gap_en = 1'(ge);
        burst = 1'(bu);
        turnaround();
        measure(n);
        chk("R6 first byte no gap", n, 0);
        for (int b = 0; b < 2; b++) begin
          @(negedge clk);
          byte_done = 1'b1;
          @(negedge clk);
          byte_done = 1'b0;
          measure(n);
          exp = (ge == 1 && bu == 1) ? 24 : 0;
          chk((exp != 0) ? "R5 gap ticks" : "R7 no gap", n, exp);
        end
        @(negedge clk);
      end
    end

    // R6: first byte uses guard, not gap
    cfg_guard_sel = 3'd4;
    cfg_gap_en = 1'b1;
    burst = 1'b1;
    turnaround();
    measure(n);
    chk("R6 first byte guard", n, 8);
    @(negedge clk);
    cfg_gap_en = 1'b0;
    burst = 1'b0;

    // R12: signature suppression
    cfg_guard_sel = 3'd7;
    byte_is_sig = 1'b1;
    cfg_sig_off = 1'b1;
    turnaround();
    chk("R12 no start for sig", int'(tx_start), 0);
    chk("R12 sig_skip", int'(sig_skip), 1);
    @(negedge clk);
    chk("R12 still held", int'(tx_start), 0);
    cfg_sig_off = 1'b0;
    #1;
    chk("R12 sig sent when enabled", int'(tx_start), 1);
    chk("R12 no skip when enabled", int'(sig_skip), 0);
    @(negedge clk);
    byte_is_sig = 1'b0;

    // R8: watchdog straight run
    byte_ready = 1'b0;
    turnaround();
    resp_wait = 1'b1;
    repeat (T - 1) @(negedge clk);
    chk("R8 no early timeout", int'(tmo_flag), 0);
    @(negedge clk);
    chk("R8 timeout", int'(tmo_flag), 1);
    resp_wait = 1'b0;
    @(negedge clk);
    chk("R8 flag clears", int'(tmo_flag), 0);

    // R8: ready pulse restarts count
    resp_wait = 1'b1;
    repeat (20) @(negedge clk);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    repeat (T - 1) @(negedge clk);
    chk("R8 restart no early", int'(tmo_flag), 0);
    @(negedge clk);
    chk("R8 restart timeout", int'(tmo_flag), 1);

    // R10: timeout aborts to idle
    byte_ready = 1'b1;
    @(negedge clk);
    tick_n(5);
    chk("R10 no start after timeout", int'(tx_start), 0);
    resp_wait = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 idle after flag clears", int'(tx_start), 0);
    turnaround();
    chk("R10 new turnaround starts", int'(tx_start), 1);
    @(negedge clk);

    // R10: receive re-entry mid-guard
    cfg_guard_sel = 3'd3;
    turnaround();
    tick_n(5);
    rx_mode = 1'b1;
    @(negedge clk);
    tick_n(20);
    chk("R10 no start in rx", int'(tx_start), 0);
    rx_mode = 1'b0;
    @(negedge clk);
    measure(n);
    chk("R10 full guard again", n, 16);
    @(negedge clk);

    // R9: watchdog disabled
    byte_ready = 1'b0;
    cfg_tmo_off = 1'b1;
    resp_wait = 1'b1;
    repeat (T + 10) @(negedge clk);
    chk("R9 no timeout when off", int'(tmo_flag), 0);
    cfg_tmo_off = 1'b0;
    repeat (T - 1) @(negedge clk);
    chk("R9 fresh count no early", int'(tmo_flag), 0);
    @(negedge clk);
    chk("R9 fresh count timeout", int'(tmo_flag), 1);
    resp_wait = 1'b0;
    @(negedge clk);

    // R11: parity qualifier
    for (int po = 0; po < 2; po++) begin
      for (int rx = 0; rx < 2; rx++) begin
        cfg_par_off = 1'(po);
        rx_mode = 1'(rx);
        @(negedge clk);
        chk("R11 par_ignore", int'(par_ignore), po & rx);
      end
    end

    finished = 1'b1;
    finish_run();
  end
endmodule